// File: doc/BRIEF.md
# Staged System Reset Sequencer

This block orders the release of reset across a prototype system after a push-button reset. The raw button level passes through a flop synchronizer and becomes an active-low system reset. When the system is built with an external DRAM controller, that controller receives the system reset directly. Every later stage then waits for the controller's calibration-complete handshake. Without a memory controller, the calibration wait is skipped.

The I/O subsystem is released next. The core wake-up logic is released after that. When the serial test loader is built in and the board switch enables it, the wake-up release waits for the loader's stream-done handshake.

A programmable number of cycles after the wake-up release, the block raises a single-cycle request to send a wake-up interrupt to core 0. Alongside that request it presents the address at which core 0 begins fetching. Pressing the button at any point returns every stage to reset and cancels any pending request. Releasing the button runs the whole sequence again.

Top module: `staged_reset_seq`

## Requirements
- R1: `sys_rst_n` is low while the button is at its active level, which is set by `BTN_ACTIVE_HIGH` (1 means a high level presses the button). After the button is released, `sys_rst_n` goes high exactly `SYNC_STAGES` cycles later (default 2).
- R2: With `HAS_DRAM`=1, `dram_rst_n` follows `sys_rst_n`. With `HAS_DRAM`=0, it stays low.
- R3: With `HAS_DRAM`=1, `io_rst_n` goes high one cycle after the first cycle in which `sys_rst_n` and `calib_done` are both high.
- R4: With `HAS_DRAM`=0, `io_rst_n` goes high one cycle after `sys_rst_n` goes high, and `calib_done` has no effect.
- R5: With `HAS_LOAD`=1 and `load_switch`=1, `wake_rst_n` goes high one cycle after the first cycle in which `io_rst_n` and `stream_done` are both high.
- R6: With `HAS_LOAD`=0, or with `load_switch`=0, `wake_rst_n` goes high one cycle after `io_rst_n` goes high, and `stream_done` has no effect.
- R7: `wake_irq` is high for exactly one cycle per reset release. It rises exactly `WAKE_DELAY` cycles after `wake_rst_n` rises. While `wake_irq` is high, `wake_pc` equals `BOOT_PC` (default 0xFFFF_F000_0020); otherwise `wake_pc` is zero.
- R8: A button press at any stage drives `io_rst_n` and `wake_rst_n` low no later than `SYNC_STAGES`+1 cycles after the press, and suppresses a pending `wake_irq`.
- R9: `wake_rst_n` is never high while `io_rst_n` is low, and `wake_irq` is never high while `wake_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| btn_raw | input | 1 | Raw push-button level, asynchronous |
| calib_done | input | 1 | Calibration complete from the DRAM controller |
| load_switch | input | 1 | Board switch that enables waiting on the serial loader |
| stream_done | input | 1 | Serial loader has finished receiving the stream |
| sys_rst_n | output | 1 | Synchronized active-low system reset |
| dram_rst_n | output | 1 | Active-low reset to the DRAM controller |
| io_rst_n | output | 1 | Active-low reset to the I/O subsystem |
| wake_rst_n | output | 1 | Active-low reset to the core wake-up logic |
| wake_irq | output | 1 | Single-cycle request to send the wake-up interrupt to core 0 |
| wake_pc | output | PC_W | Fetch start address for core 0, valid while `wake_irq` is high |

## Verification
Two handshakes can arrive together: `calib_done` and `stream_done`. The stream-done signal can also be high before the I/O stage has been released. The sweep rises each handshake at every offset in a range around the release point, including the case where both rise in the same cycle. It expects the wake-up release only one cycle after the later of the two conditions, never merged into the I/O release. A second collision is a button press that lands while the wake-up delay is running. The bench expects all stage resets to go low and no interrupt request to appear.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   typedef enum logic [1:0] {
      ST_CAL  = 2'd0,
      ST_IO   = 2'd1,
      ST_DLY  = 2'd2,
      ST_FIN  = 2'd3
   } stage_e;
endpackage

// File: rtl/rstseq_btn_sync.sv
module rstseq_btn_sync #(
   parameter bit BTN_ACTIVE_HIGH = 1'b1,
   parameter int SYNC_STAGES     = 2
) (
   input  logic clk,
   input  logic btn_raw,
   output logic sys_rst_n
);
   localparam int TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("rstseq_btn_sync: SYNC_STAGES must be at least 2");
   end

   logic pressed;
   logic [TOP:0] chain;

   if (BTN_ACTIVE_HIGH) begin : g_pol_high
      assign pressed = btn_raw;
   end else begin : g_pol_low
      assign pressed = ~btn_raw;
   end

   always_ff @(posedge clk) begin
      chain <= {chain[TOP-1:0], pressed};
   end

   assign sys_rst_n = ~chain[TOP];
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
   parameter int DELAY = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

   if (DELAY < 1) begin : g_bad_delay
      $error("rstseq_delay: DELAY must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   assign expire = run && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (!expire) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R7
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/rstseq_stage_ctrl.sv
module rstseq_stage_ctrl
   import rstseq_pkg::*;
#(
   parameter bit HAS_DRAM = 1'b1,
   parameter bit HAS_LOAD = 1'b1
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic calib_done,
   input  logic load_switch,
   input  logic stream_done,
   input  logic dly_expire,
   output logic dly_run,
   output logic io_rst_n,
   output logic wake_rst_n,
   output logic wake_irq
);
   stage_e state;
   logic   cal_ok;
   logic   load_ok;

   if (HAS_DRAM) begin : g_dram
      assign cal_ok = calib_done;
   end else begin : g_no_dram
      assign cal_ok = calib_done | 1'b1;
   end

   if (HAS_LOAD) begin : g_load
      assign load_ok = ~load_switch | stream_done;
   end else begin : g_no_load
      assign load_ok = (load_switch & stream_done) | 1'b1;
   end

   assign dly_run = (state == ST_DLY);

   always_ff @(posedge clk) begin
      if (!sys_rst_n) begin
         state      <= ST_CAL;
         io_rst_n   <= 1'b0;
         wake_rst_n <= 1'b0;
         wake_irq   <= 1'b0;
      end else begin
         wake_irq <= 1'b0;
         unique case (state)
            ST_CAL: if (cal_ok) begin
               io_rst_n <= 1'b1;
               state    <= ST_IO;
            end
            ST_IO: if (load_ok) begin
               wake_rst_n <= 1'b1;
               state      <= ST_DLY;
            end
            ST_DLY: if (dly_expire) begin
               wake_irq <= 1'b1;
               state    <= ST_FIN;
            end
            ST_FIN: state <= ST_FIN;
         endcase
      end
   end

   // R9
   wake_after_io_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      wake_rst_n |-> io_rst_n);
   // R9
   irq_needs_wake_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      wake_irq |-> wake_rst_n);
   // R7
   irq_single_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      wake_irq |=> !wake_irq);

   if (HAS_DRAM) begin : g_cal_chk
      // R3
      calib_gate_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
         $rose(io_rst_n) |-> $past(calib_done));
   end

   if (HAS_LOAD) begin : g_load_chk
      // R5
      load_gate_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
         $rose(wake_rst_n) |-> (!$past(load_switch) || $past(stream_done)));
   end
endmodule

// File: rtl/staged_reset_seq.sv
module staged_reset_seq #(
   parameter bit              BTN_ACTIVE_HIGH = 1'b1,
   parameter int              SYNC_STAGES     = 2,
   parameter bit              HAS_DRAM        = 1'b1,
   parameter bit              HAS_LOAD        = 1'b1,
   parameter int              WAKE_DELAY      = 64,
   parameter int              PC_W            = 48,
   parameter logic [PC_W-1:0] BOOT_PC         = PC_W'(48'hFFFF_F000_0020)
) (
   input  logic            clk,
   input  logic            btn_raw,
   input  logic            calib_done,
   input  logic            load_switch,
   input  logic            stream_done,
   output logic            sys_rst_n,
   output logic            dram_rst_n,
   output logic            io_rst_n,
   output logic            wake_rst_n,
   output logic            wake_irq,
   output logic [PC_W-1:0] wake_pc
);
   if (PC_W < 1) begin : g_bad_pc
      $error("staged_reset_seq: PC_W must be positive");
   end

   logic dly_run;
   logic dly_expire;

   rstseq_btn_sync #(
      .BTN_ACTIVE_HIGH (BTN_ACTIVE_HIGH),
      .SYNC_STAGES     (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .btn_raw   (btn_raw),
      .sys_rst_n (sys_rst_n)
   );

   if (HAS_DRAM) begin : g_dram_rst
      assign dram_rst_n = sys_rst_n;
   end else begin : g_dram_hold
      assign dram_rst_n = 1'b0;
   end

   rstseq_stage_ctrl #(
      .HAS_DRAM (HAS_DRAM),
      .HAS_LOAD (HAS_LOAD)
   ) u_ctrl (
      .clk         (clk),
      .sys_rst_n   (sys_rst_n),
      .calib_done  (calib_done),
      .load_switch (load_switch),
      .stream_done (stream_done),
      .dly_expire  (dly_expire),
      .dly_run     (dly_run),
      .io_rst_n    (io_rst_n),
      .wake_rst_n  (wake_rst_n),
      .wake_irq    (wake_irq)
   );

   rstseq_delay #(
      .DELAY (WAKE_DELAY)
   ) u_delay (
      .clk    (clk),
      .rst_n  (sys_rst_n),
      .run    (dly_run),
      .expire (dly_expire)
   );

   assign wake_pc = wake_irq ? BOOT_PC : '0;
endmodule

// File: tb/sim_staged_reset_seq.sv
module sim_staged_reset_seq;
   localparam int D0 = 5;
   localparam int D1 = 3;
   localparam logic [47:0] BOOT = 48'hFFFF_F000_0020;

   logic clk = 1'b0;
   logic btn = 1'b1;
   logic btn_n = 1'b0;
   logic calib = 1'b0;
   logic sw = 1'b0;
   logic done = 1'b0;

   logic sys0, dram0, io0, wake0, irq0;
   logic sys1, dram1, io1, wake1, irq1;
   logic [47:0] pc0, pc1;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   staged_reset_seq #(.HAS_DRAM(1'b1), .HAS_LOAD(1'b1), .WAKE_DELAY(D0)) u0 (
      .clk(clk), .btn_raw(btn), .calib_done(calib), .load_switch(sw),
      .stream_done(done), .sys_rst_n(sys0), .dram_rst_n(dram0),
      .io_rst_n(io0), .wake_rst_n(wake0), .wake_irq(irq0), .wake_pc(pc0));

   staged_reset_seq #(.BTN_ACTIVE_HIGH(1'b0), .HAS_DRAM(1'b0), .HAS_LOAD(1'b0),
                      .WAKE_DELAY(D1)) u1 (
      .clk(clk), .btn_raw(btn_n), .calib_done(calib), .load_switch(sw),
      .stream_done(done), .sys_rst_n(sys1), .dram_rst_n(dram1),
      .io_rst_n(io1), .wake_rst_n(wake1), .wake_irq(irq1), .wake_pc(pc1));

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic press(int n);
      btn = 1'b1; btn_n = 1'b0; calib = 1'b0; done = 1'b0;
      repeat (n) @(negedge clk);
      chk("R1 sys low in reset u0", sys0, 0);
      chk("R1 sys low in reset u1", sys1, 0);
      chk("R2 dram low in reset", dram0, 0);
      chk("R8 io low in reset", io0 | io1, 0);
      chk("R8 wake low in reset", wake0 | wake1, 0);
      chk("R7 no irq in reset", irq0 | irq1, 0);
   endtask

   function automatic int mx(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic run_case(int ct, int sw_v, int dt);
      int s0 = -1, i0 = -1, w0 = -1, q0 = -1, n0 = 0;
      int s1 = -1, i1 = -1, w1 = -1, q1 = -1, n1 = 0;
      int e_i0, e_w0;
      press(4);
      sw = sw_v[0];
      btn = 1'b0; btn_n = 1'b1;
      calib = (ct <= 0); done = (dt <= 0);
      for (int t = 1; t <= 40; t++) begin
         @(negedge clk);
         if (sys0 && s0 < 0) s0 = t;
         if (io0 && i0 < 0) i0 = t;
         if (wake0 && w0 < 0) w0 = t;
         if (irq0) begin n0++; q0 = t; chk("R7 wake_pc u0", pc0, BOOT); end
         if (sys1 && s1 < 0) s1 = t;
         if (io1 && i1 < 0) i1 = t;
         if (wake1 && w1 < 0) w1 = t;
         if (irq1) begin n1++; q1 = t; chk("R7 wake_pc u1", pc1, BOOT); end
         else chk("R7 wake_pc idle u1", pc1, 0);
         calib = (t >= ct);
         done = (t >= dt);
      end
      e_i0 = mx(3, ct + 1);
      e_w0 = (sw_v != 0) ? mx(e_i0 + 1, dt + 1) : e_i0 + 1;
      chk("R1 sys release u0", s0, 2);
      chk("R1 sys release u1 active-low button", s1, 2);
      chk("R2 dram follows sys", dram0, 1);
      chk("R2 dram held when absent", dram1, 0);
      chk("R3 io after calib", i0, e_i0);
      chk("R4 io without dram", i1, 3);
      if (sw_v != 0) chk("R5 wake after stream done", w0, e_w0);
      else chk("R6 wake with switch off", w0, e_w0);
      chk("R6 wake without loader", w1, 4);
      chk("R7 irq time u0", q0, e_w0 + D0);
      chk("R7 irq count u0", n0, 1);
      chk("R7 irq time u1", q1, 4 + D1);
      chk("R7 irq count u1", n1, 1);
   endtask

   task automatic abort_case();
      int n = 0;
      press(4);
      sw = 1'b1;
      btn = 1'b0; btn_n = 1'b1; calib = 1'b1; done = 1'b1;
      for (int t = 1; t <= 20 && !wake0; t++) @(negedge clk);
      chk("R8 wake reached before abort", wake0, 1);
      btn = 1'b1; btn_n = 1'b0;
      for (int t = 1; t <= 12; t++) begin
         @(negedge clk);
         if (irq0 || irq1) n++;
         if (t == 3) begin
            chk("R8 io low after abort", io0, 0);
            chk("R8 wake low after abort", wake0, 0);
         end
      end
      chk("R8 irq suppressed by abort", n, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      for (int ct = 0; ct <= 4; ct++)
         for (int s = 0; s <= 1; s++)
            for (int dt = 0; dt <= 6; dt++)
               run_case(ct, s, dt);
      abort_case();
      run_case(2, 1, 5);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule